// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This block decides which exception a processor core with a byte-wide emulation mode and a 16-bit native mode takes next, and it describes that entry to the rest of the core. Four hardware sources each hold a pending bit: reset, non-maskable interrupt, maskable interrupt and bus abort. A request pulse on a source's input sets its bit. When no hardware source qualifies, the software trap of the current instruction is taken. An opcode of 0x00 is a break trap, and any other opcode is a coprocessor trap.

When the sequencer raises `entry_req`, the block picks a source and clears that source's pending bit. One cycle later it presents the 16-bit vector address, the stack frame with its byte count, and one-cycle strobes. The strobes tell the core to clear the program bank, set the interrupt-disable flag, skip one sequencer step, reset the mode register, or restore the start-of-instruction register snapshot after an abort.

The block also qualifies wake-up from the two idle states. While the core waits for an interrupt or is stopped and no qualifying source is pending, the block asks for a no-operation bus cycle at the all-ones address.

Top module: `exc_vector_unit`

## Requirements
- R1: Hardware sources are ranked reset first, then non-maskable interrupt, then maskable interrupt, then abort. The software trap is taken only when no hardware source qualifies. At most one of `mode_reset` and `abort_restore` pulses per entry.
- R2: An entry clears only the pending bit of the chosen source. The other pending sources are taken on later entries in priority order.
- R3: Release of `rst_n` leaves a power-on reset pending. A reset entry gives vector 0xFFFC in both modes and pulses `mode_reset`.
- R4: The non-maskable interrupt vector is 0xFFFA in emulation mode and 0xFFEA in native mode. The maskable interrupt vector is 0xFFFE in emulation mode and 0xFFEE in native mode.
- R5: A pending maskable interrupt is passed over while status bit 2 (interrupt disable) is 1. It stays pending.
- R6: The abort vector is 0xFFF8 in emulation mode and 0xFFE8 in native mode. `abort_restore` pulses only on an abort entry.
- R7: The break trap (opcode 0x00) uses 0xFFFE in emulation mode and 0xFFE6 in native mode. The coprocessor trap uses 0xFFF4 in emulation mode and 0xFFE4 in native mode.
- R8: In emulation mode the frame is {8'h00, pc, status}, with status bit 4 forced to 1 for a break trap. `frame_bytes` is 3 and `skip_step` pulses.
- R9: In native mode the frame is {pbank, pc, status}. `frame_bytes` is 4 and `pbank_clear` pulses.
- R10: `entry_done` and `set_idisable` pulse for exactly one cycle, in the cycle after `entry_req`.
- R11: While `wai_idle` is 1, `idle_nop` stays 1 until a reset, non-maskable or maskable interrupt is pending. The maskable interrupt wakes the core even when it is masked. An abort does not wake it.
- R12: While `stp_idle` is 1, only a pending reset clears `idle_nop`.
- R13: `idle_addr` is all ones whenever `idle_nop` is 1, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Pulse that sets the reset pending bit |
| nmi_req | input | 1 | Pulse that sets the non-maskable interrupt pending bit |
| irq_req | input | 1 | Pulse that sets the maskable interrupt pending bit |
| abort_req | input | 1 | Pulse that sets the abort pending bit |
| entry_req | input | 1 | Sequencer asks for an exception entry |
| emu_mode | input | 1 | 1 for emulation mode, 0 for native mode |
| status | input | 8 | Processor status byte (bit 2 interrupt disable, bit 4 break) |
| pc | input | 16 | Program counter to save |
| pbank | input | 8 | Program bank to save |
| opcode | input | 8 | Opcode of the current instruction |
| wai_idle | input | 1 | Core is waiting for an interrupt |
| stp_idle | input | 1 | Core is stopped |
| entry_done | output | 1 | Entry result valid (one-cycle pulse) |
| vector | output | 16 | Vector address of the chosen source |
| frame | output | 32 | Stack frame value, least significant byte is status |
| frame_bytes | output | 3 | Number of frame bytes to push |
| skip_step | output | 1 | Skip one sequencer step (emulation-mode entry) |
| pbank_clear | output | 1 | Clear the program bank (native-mode entry) |
| set_idisable | output | 1 | Set the interrupt-disable flag |
| abort_restore | output | 1 | Reload the start-of-instruction register snapshot |
| mode_reset | output | 1 | Put the mode register into its reset state |
| idle_nop | output | 1 | Drive a no-operation bus cycle this cycle |
| idle_addr | output | 24 | Address for the idle bus cycle |

## Verification
The assertions assume three things about the inputs. `entry_req` is low while reset is asserted. `pbank` is stable in the cycle that carries `entry_req`, so the saved bank can be compared with its value one cycle earlier. The two idle flags are never both high.

The bench drives every input on the falling edge and keeps `entry_req` at a single-cycle pulse. It raises one idle flag at a time. It also lets the previous entry finish before it requests the next, so each result is sampled where it is valid.

// File: rtl/exc_pkg.sv
package exc_pkg;
   // Source index doubles as priority rank: lower index wins.
   typedef enum logic [2:0] {
      SRC_RESET = 3'd0,
      SRC_NMI   = 3'd1,
      SRC_IRQ   = 3'd2,
      SRC_ABORT = 3'd3,
      SRC_TRAP  = 3'd4
   } exc_src_e;

   localparam int HW_SRCS = 4;
endpackage

// File: rtl/exc_pending.sv
module exc_pending #(
   parameter int NSRC     = 4,
   parameter bit POR_PEND = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] pend_o
);
   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      // Bit 0 is the reset source; it may come out of reset already pending.
      localparam logic RST_VAL = (g == 0) ? POR_PEND : 1'b0;
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= RST_VAL;
         else if (set_i[g])   q <= 1'b1;   // a fresh request outranks the clear
         else if (clr_i[g])   q <= 1'b0;
      end
      assign pend_o[g] = q;
   end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int NSRC = 4
) (
   input  logic [NSRC-1:0] pend_i,
   input  logic            irq_masked_i,
   output exc_src_e        src_o,
   output logic [NSRC-1:0] take_o
);
   logic [NSRC-1:0] elig;

   always_comb begin
      elig = pend_i;
      elig[int'(SRC_IRQ)] = pend_i[int'(SRC_IRQ)] & ~irq_masked_i;
      take_o = '0;
      src_o  = SRC_TRAP;
      // Walk from lowest rank up so the highest-priority eligible source is kept last.
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            take_o    = '0;
            take_o[i] = 1'b1;
            src_o     = exc_src_e'(3'(i));
         end
      end
   end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
   import exc_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int BANK_W  = 8,
   parameter int STAT_W  = 8,
   parameter int OP_W    = 8,
   parameter int VEC_W   = 16,
   parameter int BRK_BIT = 4,
   parameter logic [VEC_W-1:0] V_RESET  = 16'hFFFC,
   parameter logic [VEC_W-1:0] V_NMI_E  = 16'hFFFA,
   parameter logic [VEC_W-1:0] V_NMI_N  = 16'hFFEA,
   parameter logic [VEC_W-1:0] V_IRQ_E  = 16'hFFFE,
   parameter logic [VEC_W-1:0] V_IRQ_N  = 16'hFFEE,
   parameter logic [VEC_W-1:0] V_ABT_E  = 16'hFFF8,
   parameter logic [VEC_W-1:0] V_ABT_N  = 16'hFFE8,
   parameter logic [VEC_W-1:0] V_BRK_E  = 16'hFFFE,
   parameter logic [VEC_W-1:0] V_BRK_N  = 16'hFFE6,
   parameter logic [VEC_W-1:0] V_COP_E  = 16'hFFF4,
   parameter logic [VEC_W-1:0] V_COP_N  = 16'hFFE4,
   localparam int FRAME_W   = BANK_W + PC_W + STAT_W,
   localparam int NAT_BYTES = FRAME_W / 8,
   localparam int EMU_BYTES = (PC_W + STAT_W) / 8,
   localparam int BYTES_W   = $clog2(NAT_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  exc_src_e           src_i,
   input  logic               emu_i,
   input  logic [STAT_W-1:0]  stat_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [BANK_W-1:0]  bank_i,
   input  logic [OP_W-1:0]    op_i,
   output logic               done_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic [BYTES_W-1:0] bytes_o,
   output logic               skip_o,
   output logic               bclr_o,
   output logic               idis_o,
   output logic               abrt_o,
   output logic               mrst_o
);
   localparam logic [STAT_W-1:0] BRK_MASK = STAT_W'(1) << BRK_BIT;

   logic               is_brk;
   logic [VEC_W-1:0]   vec_n;
   logic [FRAME_W-1:0] frame_n;
   logic [BYTES_W-1:0] bytes_n;

   assign is_brk = (src_i == SRC_TRAP) && (op_i == '0);

   always_comb begin
      unique case (src_i)
         SRC_RESET: vec_n = V_RESET;
         SRC_NMI:   vec_n = emu_i ? V_NMI_E : V_NMI_N;
         SRC_IRQ:   vec_n = emu_i ? V_IRQ_E : V_IRQ_N;
         SRC_ABORT: vec_n = emu_i ? V_ABT_E : V_ABT_N;
         default:   vec_n = is_brk ? (emu_i ? V_BRK_E : V_BRK_N)
                                   : (emu_i ? V_COP_E : V_COP_N);
      endcase
      if (emu_i) begin
         frame_n = {{BANK_W{1'b0}}, pc_i, stat_i | (is_brk ? BRK_MASK : '0)};
         bytes_n = BYTES_W'(EMU_BYTES);
      end else begin
         frame_n = {bank_i, pc_i, stat_i};
         bytes_n = BYTES_W'(NAT_BYTES);
      end
   end

   // Result registers hold until the next entry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o   <= '0;
         frame_o <= '0;
         bytes_o <= '0;
      end else if (load_i) begin
         vec_o   <= vec_n;
         frame_o <= frame_n;
         bytes_o <= bytes_n;
      end
   end

   // Strobes last exactly one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         skip_o <= 1'b0;
         bclr_o <= 1'b0;
         idis_o <= 1'b0;
         abrt_o <= 1'b0;
         mrst_o <= 1'b0;
      end else begin
         done_o <= load_i;
         skip_o <= load_i & emu_i;
         bclr_o <= load_i & ~emu_i;
         idis_o <= load_i;
         abrt_o <= load_i & (src_i == SRC_ABORT);
         mrst_o <= load_i & (src_i == SRC_RESET);
      end
   end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
   import exc_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int BANK_W    = 8,
   parameter int STAT_W    = 8,
   parameter int OP_W      = 8,
   parameter int VEC_W     = 16,
   parameter int ADDR_W    = 24,
   parameter int IFLAG_BIT = 2,
   parameter int BRK_BIT   = 4,
   parameter bit POR_PEND  = 1'b1,
   localparam int FRAME_W  = BANK_W + PC_W + STAT_W,
   localparam int BYTES_W  = $clog2(FRAME_W / 8 + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reset_req,
   input  logic               nmi_req,
   input  logic               irq_req,
   input  logic               abort_req,
   input  logic               entry_req,
   input  logic               emu_mode,
   input  logic [STAT_W-1:0]  status,
   input  logic [PC_W-1:0]    pc,
   input  logic [BANK_W-1:0]  pbank,
   input  logic [OP_W-1:0]    opcode,
   input  logic               wai_idle,
   input  logic               stp_idle,
   output logic               entry_done,
   output logic [VEC_W-1:0]   vector,
   output logic [FRAME_W-1:0] frame,
   output logic [BYTES_W-1:0] frame_bytes,
   output logic               skip_step,
   output logic               pbank_clear,
   output logic               set_idisable,
   output logic               abort_restore,
   output logic               mode_reset,
   output logic               idle_nop,
   output logic [ADDR_W-1:0]  idle_addr
);
   if (IFLAG_BIT >= STAT_W || BRK_BIT >= STAT_W) begin : g_bad_bits
      $error("flag bit positions must lie inside the status byte");
   end
   if ((FRAME_W % 8) != 0 || ((PC_W + STAT_W) % 8) != 0) begin : g_bad_frame
      $error("frame fields must pack into whole bytes");
   end
   if (HW_SRCS < 4) begin : g_bad_srcs
      $error("four hardware sources are required");
   end

   logic [HW_SRCS-1:0] req_vec, pend, take, clr;
   exc_src_e           src;
   logic               wai_wake, stp_wake;

   assign req_vec = {abort_req, irq_req, nmi_req, reset_req};
   assign clr     = entry_req ? take : '0;

   exc_pending #(.NSRC(HW_SRCS), .POR_PEND(POR_PEND)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_vec),
      .clr_i  (clr),
      .pend_o (pend)
   );

   exc_arbiter #(.NSRC(HW_SRCS)) u_arb (
      .pend_i       (pend),
      .irq_masked_i (status[IFLAG_BIT]),
      .src_o        (src),
      .take_o       (take)
   );

   exc_frame #(
      .PC_W(PC_W), .BANK_W(BANK_W), .STAT_W(STAT_W), .OP_W(OP_W),
      .VEC_W(VEC_W), .BRK_BIT(BRK_BIT)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (entry_req),
      .src_i   (src),
      .emu_i   (emu_mode),
      .stat_i  (status),
      .pc_i    (pc),
      .bank_i  (pbank),
      .op_i    (opcode),
      .done_o  (entry_done),
      .vec_o   (vector),
      .frame_o (frame),
      .bytes_o (frame_bytes),
      .skip_o  (skip_step),
      .bclr_o  (pbank_clear),
      .idis_o  (set_idisable),
      .abrt_o  (abort_restore),
      .mrst_o  (mode_reset)
   );

   // Wait state ends on reset or either interrupt, masked or not; stop ends on reset only.
   assign wai_wake  = pend[int'(SRC_RESET)] | pend[int'(SRC_NMI)] | pend[int'(SRC_IRQ)];
   assign stp_wake  = pend[int'(SRC_RESET)];
   assign idle_nop  = (wai_idle & ~wai_wake) | (stp_idle & ~stp_wake);
   assign idle_addr = {ADDR_W{idle_nop}};
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
   parameter int FRAME_W = 32,
   parameter int BANK_W  = 8,
   parameter int BYTES_W = 3,
   parameter int VEC_W   = 16,
   parameter int ADDR_W  = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               entry_req,
   input logic [BANK_W-1:0]  pbank,
   input logic               wai_idle,
   input logic               stp_idle,
   input logic               entry_done,
   input logic [VEC_W-1:0]   vector,
   input logic [FRAME_W-1:0] frame,
   input logic [BYTES_W-1:0] frame_bytes,
   input logic               skip_step,
   input logic               pbank_clear,
   input logic               set_idisable,
   input logic               abort_restore,
   input logic               mode_reset,
   input logic               idle_nop,
   input logic [ADDR_W-1:0]  idle_addr
);
   localparam logic [BYTES_W-1:0] NAT_B = BYTES_W'(FRAME_W / 8);
   localparam logic [BYTES_W-1:0] EMU_B = BYTES_W'(FRAME_W / 8 - BANK_W / 8);

   p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      entry_req |=> entry_done);
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_req |=> !entry_done);
   p_idisable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> set_idisable);
   p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mode_reset, abort_restore}));
   p_reset_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_reset |-> entry_done && vector == 16'hFFFC);
   p_abort_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_restore |-> entry_done && (vector == 16'hFFF8 || vector == 16'hFFE8));
   p_emu_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_step |-> frame_bytes == EMU_B && !pbank_clear && frame[FRAME_W-1 -: BANK_W] == '0);
   p_nat_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pbank_clear |-> frame_bytes == NAT_B && frame[FRAME_W-1 -: BANK_W] == $past(pbank));
   p_idle_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
      idle_nop |-> (wai_idle || stp_idle) && idle_addr == {ADDR_W{1'b1}});
endmodule

bind exc_vector_unit exc_vector_unit_chk #(
   .FRAME_W(FRAME_W), .BANK_W(BANK_W), .BYTES_W(BYTES_W),
   .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .pbank(pbank),
   .wai_idle(wai_idle), .stp_idle(stp_idle), .entry_done(entry_done),
   .vector(vector), .frame(frame), .frame_bytes(frame_bytes),
   .skip_step(skip_step), .pbank_clear(pbank_clear), .set_idisable(set_idisable),
   .abort_restore(abort_restore), .mode_reset(mode_reset),
   .idle_nop(idle_nop), .idle_addr(idle_addr)
);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
   localparam logic [15:0] PCV  = 16'h1234;
   localparam logic [7:0]  PBV  = 8'h5C;
   localparam logic [7:0]  STB  = 8'hA1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reset_req = 1'b0, nmi_req = 1'b0, irq_req = 1'b0, abort_req = 1'b0;
   logic        entry_req = 1'b0, emu_mode = 1'b1;
   logic [7:0]  status = STB;
   logic [15:0] pc = PCV;
   logic [7:0]  pbank = PBV;
   logic [7:0]  opcode = 8'h02;
   logic        wai_idle = 1'b0, stp_idle = 1'b0;
   logic        entry_done, skip_step, pbank_clear, set_idisable;
   logic        abort_restore, mode_reset, idle_nop;
   logic [15:0] vector;
   logic [31:0] frame;
   logic [2:0]  frame_bytes;
   logic [23:0] idle_addr;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   exc_vector_unit uut (
      .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
      .irq_req(irq_req), .abort_req(abort_req), .entry_req(entry_req),
      .emu_mode(emu_mode), .status(status), .pc(pc), .pbank(pbank),
      .opcode(opcode), .wai_idle(wai_idle), .stp_idle(stp_idle),
      .entry_done(entry_done), .vector(vector), .frame(frame),
      .frame_bytes(frame_bytes), .skip_step(skip_step), .pbank_clear(pbank_clear),
      .set_idisable(set_idisable), .abort_restore(abort_restore),
      .mode_reset(mode_reset), .idle_nop(idle_nop), .idle_addr(idle_addr)
   );

   // Row: {mask abort,irq,nmi,reset}, emu, idisable, opcode, expected vector
   localparam logic [29:0] TBL [14] = '{
      {4'b0010, 1'b1, 1'b0, 8'h02, 16'hFFFA},   // R4 nmi emu
      {4'b0010, 1'b0, 1'b0, 8'h02, 16'hFFEA},   // R4 nmi native
      {4'b0100, 1'b1, 1'b0, 8'h02, 16'hFFFE},   // R4 irq emu
      {4'b0100, 1'b0, 1'b0, 8'h02, 16'hFFEE},   // R4 irq native
      {4'b1000, 1'b1, 1'b0, 8'h02, 16'hFFF8},   // R6 abort emu
      {4'b1000, 1'b0, 1'b0, 8'h02, 16'hFFE8},   // R6 abort native
      {4'b0000, 1'b1, 1'b0, 8'h00, 16'hFFFE},   // R7 brk emu
      {4'b0000, 1'b0, 1'b0, 8'h00, 16'hFFE6},   // R7 brk native
      {4'b0000, 1'b1, 1'b0, 8'h02, 16'hFFF4},   // R7 cop emu
      {4'b0000, 1'b0, 1'b0, 8'h02, 16'hFFE4},   // R7 cop native
      {4'b0100, 1'b0, 1'b1, 8'h02, 16'hFFE4},   // R5 masked irq -> cop
      {4'b0110, 1'b0, 1'b0, 8'h02, 16'hFFEA},   // R1 nmi over irq
      {4'b1100, 1'b0, 1'b0, 8'h02, 16'hFFEE},   // R1 irq over abort
      {4'b0011, 1'b1, 1'b0, 8'h02, 16'hFFFC}    // R1 reset over nmi
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic post(input logic [3:0] m);
      {abort_req, irq_req, nmi_req, reset_req} = m;
      @(negedge clk);
      {abort_req, irq_req, nmi_req, reset_req} = 4'b0;
   endtask

   task automatic enter;
      entry_req = 1'b1;
      @(negedge clk);
      entry_req = 1'b0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      check("R10 reset entry_done", 32'(entry_done), 0);
      check("R13 reset idle_nop", 32'(idle_nop), 0);
      check("R10 reset vector", 32'(vector), 0);

      // Vector table walk
      for (int r = 0; r < 14; r++) begin
         logic [3:0] m, elig;
         logic       e, ib, trap, brk;
         logic [7:0] st;
         logic [31:0] fexp;
         m = TBL[r][29:26]; e = TBL[r][25]; ib = TBL[r][24];
         do_reset;
         emu_mode = 1'b1; status = STB;
         enter;                                   // power-on entry (R3)
         check("R3 power-on vector", 32'(vector), 32'hFFFC);
         check("R3 power-on mode_reset", 32'(mode_reset), 1);
         emu_mode = e; opcode = TBL[r][23:16];
         st = STB | (ib ? 8'h04 : 8'h00); status = st;
         post(m);
         enter;
         elig = m & ~(ib ? 4'b0100 : 4'b0000);
         trap = (elig == 4'b0);
         brk  = trap && opcode == 8'h00;
         fexp = e ? {8'h00, PCV, st | (brk ? 8'h10 : 8'h00)} : {PBV, PCV, st};
         check($sformatf("R1 row %0d vector", r), 32'(vector), 32'(TBL[r][15:0]));
         check($sformatf("R8/R9 row %0d frame", r), frame, fexp);
         check($sformatf("R8 R9 row %0d bytes", r), 32'(frame_bytes), e ? 3 : 4);
         check($sformatf("R8 row %0d skip", r), 32'(skip_step), 32'(e));
         check($sformatf("R9 row %0d pbank_clear", r), 32'(pbank_clear), 32'(!e));
         check($sformatf("R6 row %0d abort_restore", r), 32'(abort_restore),
               32'(elig[3] && elig[2:0] == 3'b0));
         check($sformatf("R3 row %0d mode_reset", r), 32'(mode_reset), 32'(elig[0]));
         check($sformatf("R10 row %0d idisable", r), 32'(set_idisable), 1);
      end

      // R2: drain several pending sources in order
      do_reset;
      emu_mode = 1'b0; status = STB; opcode = 8'h02;
      enter;
      post(4'b1110);
      enter;
      check("R2 first nmi", 32'(vector), 32'hFFEA);
      @(negedge clk);
      check("R10 done one cycle", 32'(entry_done), 0);
      check("R10 idisable one cycle", 32'(set_idisable), 0);
      enter;
      check("R2 then irq", 32'(vector), 32'hFFEE);
      enter;
      check("R2 then abort", 32'(vector), 32'hFFE8);
      check("R6 abort strobe", 32'(abort_restore), 1);
      enter;
      check("R2 then trap", 32'(vector), 32'hFFE4);
      check("R6 no abort strobe", 32'(abort_restore), 0);

      // R11 wait wake-up
      wai_idle = 1'b1;
      do_reset;
      check("R3 power-on wakes wait", 32'(idle_nop), 0);
      enter;
      check("R11 idle while nothing pending", 32'(idle_nop), 1);
      check("R13 idle address", 32'(idle_addr), 32'h00FF_FFFF);
      post(4'b1000);
      check("R11 abort does not wake", 32'(idle_nop), 1);
      status = STB | 8'h04;
      post(4'b0100);
      check("R11 masked irq wakes", 32'(idle_nop), 0);
      check("R13 address zero when awake", 32'(idle_addr), 0);
      wai_idle = 1'b0;

      // R12 stop wake-up
      do_reset;
      enter;
      stp_idle = 1'b1;
      @(negedge clk);
      check("R12 stopped", 32'(idle_nop), 1);
      post(4'b0010);
      check("R12 nmi keeps stop", 32'(idle_nop), 1);
      post(4'b0100);
      check("R12 irq keeps stop", 32'(idle_nop), 1);
      post(4'b0001);
      check("R12 reset ends stop", 32'(idle_nop), 0);
      stp_idle = 1'b0;

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule